// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache with Early Restart

This block is a data cache placed between a processor load/store port and a slower backing memory that moves whole lines as bursts of words. Each address picks exactly one line slot. The slot holds a group of neighbouring words under a single stored tag, plus a valid flag and a modified flag. Loads and stores that find their line complete in the same cycle and never touch the backing port. A store hit changes only the cached copy and marks the line modified.

On a miss the processor is stalled. If the slot holds a modified line, that line is first streamed out to the backing port. The wanted line is then streamed in, lowest word first. The stall is lifted in the exact beat that delivers the word the processor asked for, and the rest of the line keeps arriving in the background. A store miss fetches the full line and merges the store's enabled bytes into the arriving word. The processor side is a plain request/ready handshake: the request and its fields stay stable until `cpu_ready` is seen high at a clock edge.

Top module: `line_cache_ctrl`

## Requirements
- R1: After reset every slot is invalid and unmodified. `mem_req` and `cpu_ready` are low with no request, and the first access to any address misses.
- R2: A word address splits into tag (upper bits), slot index (the IDX_W bits above the offset) and word offset (the low OFF_W bits). A hit needs a valid slot with an equal tag. Another tag at the same index misses and replaces the slot.
- R3: A load hit raises `cpu_ready` in the cycle the request is presented, with the cached word on `cpu_rdata`, while the backing port stays idle.
- R4: A store hit completes in the same cycle and writes only the bytes whose `cpu_be` bit is set (bit b covers data bits 8b+7..8b). It marks the line modified and causes no backing traffic.
- R5: A miss refills the line with `mem_we` low, at line address {tag, index}. It takes LINE_WORDS beats, one per `mem_ack`, in ascending order starting at word 0, and the line is valid afterwards.
- R6: A victim that is invalid or unmodified is never written back; the refill starts directly.
- R7: A modified victim is written back before the refill. This is LINE_WORDS beats with `mem_we` high at the victim's line address, words ascending from 0, and they carry the latest stored values.
- R8: On a miss, `cpu_ready` rises only in the refill beat whose word offset equals the requested offset, and a load receives that beat's `mem_rdata`.
- R9: A store miss allocates the line, then merges the enabled bytes into the fetched word. Later loads see the merged word and the line is modified.
- R10: Once the critical word has been delivered and the refill is still running, any new request stalls until the refill finishes.
- R11: A burst advances only on beats with `mem_ack` high. Gaps in `mem_ack` neither skip nor repeat a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_be | input | DATA_W/8 | Store byte enables |
| cpu_ready | output | 1 | Request completes at this edge |
| cpu_rdata | output | DATA_W | Load data, valid with cpu_ready |
| mem_req | output | 1 | Burst in progress |
| mem_we | output | 1 | 1 = write-back burst, 0 = refill burst |
| mem_line_addr | output | ADDR_W-OFF_W | Line address of the burst |
| mem_wdata | output | DATA_W | Write-back word for the current beat |
| mem_ack | input | 1 | Backing memory moves one word this cycle |
| mem_rdata | input | DATA_W | Refill word for the current beat |

## Verification
The bench targets the critical-word beat at every offset, including offset 0 and the final word. A design that releases the stall early hands over a word from the wrong beat, and one that releases it late shows up as a readiness mismatch. Requests issued back to back right after an early release check that nothing is served while the refill is still running. Mixed stores with random byte enables, conflicting tags and an irregular `mem_ack` pattern stress the write-back path. A dropped modified flag, a missed merge or a beat counted without an acknowledge leaves stale data in the backing model or in a later load.

// File: rtl/cache_ctrl_pkg.sv
`timescale 1ns/1ps
// Shared types for the cache controller.
// Assumes nothing beyond standard SystemVerilog.
package cache_ctrl_pkg;
    // Miss sequencer states: waiting, streaming a victim out, streaming a line in.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WRBACK = 2'd1,
        ST_REFILL = 2'd2
    } miss_state_t;
endpackage

// File: rtl/cache_miss_fsm.sv
`timescale 1ns/1ps
// Miss sequencer: on a miss it optionally streams the victim line out, then
// streams the new line in, counting beats on mem_ack.
// Assumes LINE_WORDS is a power of two and at least 2; beats run from word 0 up.
module cache_miss_fsm
    import cache_ctrl_pkg::*;
#(
    parameter int LINE_WORDS = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          miss_start,
    input  logic                          victim_dirty,
    input  logic                          mem_ack,
    output miss_state_t                   state_o,
    output logic [$clog2(LINE_WORDS)-1:0] beat_o,
    output logic                          last_beat_o
);
    localparam int OFF_W = $clog2(LINE_WORDS);

    miss_state_t      state_q;
    logic [OFF_W-1:0] beat_q;

    assign state_o     = state_q;
    assign beat_o      = beat_q;
    assign last_beat_o = (beat_q == OFF_W'(LINE_WORDS - 1));

    // Advance the sequencer and the beat counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    beat_q <= '0;
                    if (miss_start) begin
                        state_q <= victim_dirty ? ST_WRBACK : ST_REFILL;
                    end
                end
                ST_WRBACK: begin
                    if (mem_ack) begin
                        beat_q <= beat_q + 1'b1;
                        if (last_beat_o) begin
                            state_q <= ST_REFILL;
                        end
                    end
                end
                ST_REFILL: begin
                    if (mem_ack) begin
                        beat_q <= beat_q + 1'b1;
                        if (last_beat_o) begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_CLEAN_SKIPS_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && miss_start && !victim_dirty) |=> (state_q == ST_REFILL)); // R6
    AST_DIRTY_WRITES_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && miss_start && victim_dirty) |=> (state_q == ST_WRBACK)); // R7
    AST_BEAT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !mem_ack) |=> ($stable(beat_q) && $stable(state_q))); // R11
    AST_BURST_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && miss_start) |=> (beat_q == '0)); // R5
endmodule

// File: rtl/cache_tag_store.sv
`timescale 1ns/1ps
// Tag, valid and modified flags for every line slot.
// Reads are combinational; updates happen at the clock edge. A refill writes
// the tag, sets valid and loads the modified flag; a store hit sets modified.
module cache_tag_store #(
    parameter int NUM_LINES = 16,
    parameter int TAG_W     = 10
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [$clog2(NUM_LINES)-1:0] rd_idx,
    output logic                         rd_valid,
    output logic                         rd_dirty,
    output logic [TAG_W-1:0]             rd_tag,
    input  logic                         mark_dirty,
    input  logic [$clog2(NUM_LINES)-1:0] mark_idx,
    input  logic                         fill_en,
    input  logic [$clog2(NUM_LINES)-1:0] fill_idx,
    input  logic [TAG_W-1:0]             fill_tag,
    input  logic                         fill_dirty
);
    logic [NUM_LINES-1:0] valid_q;
    logic [NUM_LINES-1:0] dirty_q;
    logic [TAG_W-1:0]     tag_q [NUM_LINES];

    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];

    // Clear all flags at reset; install refilled lines and mark stores.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            if (fill_en) begin
                valid_q[fill_idx] <= 1'b1;
                dirty_q[fill_idx] <= fill_dirty;
            end
            if (mark_dirty) begin
                dirty_q[mark_idx] <= 1'b1;
            end
        end
    end

    // Tag storage needs no reset: it is only read behind a valid flag.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[fill_idx] <= fill_tag;
        end
    end

    AST_FILL_VALIDATES: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> valid_q[$past(fill_idx)]); // R5
    AST_DIRTY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rd_dirty |-> rd_valid); // R6
endmodule

// File: rtl/cache_data_store.sv
`timescale 1ns/1ps
// Word storage for all lines: two combinational read ports and one write
// port with byte enables. Contents are not reset; validity lives in the tags.
module cache_data_store #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic [$clog2(DEPTH)-1:0] ra_addr,
    output logic [DATA_W-1:0]        ra_data,
    input  logic [$clog2(DEPTH)-1:0] rb_addr,
    output logic [DATA_W-1:0]        rb_data,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_addr,
    input  logic [DATA_W/8-1:0]      wr_be,
    input  logic [DATA_W-1:0]        wr_data
);
    localparam int BE_W = DATA_W / 8;

    logic [DATA_W-1:0] words_q [DEPTH];

    assign ra_data = words_q[ra_addr];
    assign rb_data = words_q[rb_addr];

    for (genvar b = 0; b < BE_W; b++) begin : g_byte
        // Write one byte lane when enabled.
        always_ff @(posedge clk) begin
            if (wr_en && wr_be[b]) begin
                words_q[wr_addr][b*8 +: 8] <= wr_data[b*8 +: 8];
            end
        end
    end
endmodule

// File: rtl/line_cache_ctrl.sv
`timescale 1ns/1ps
// Direct-mapped write-back data cache with allocate on store miss and early
// restart. Hits finish in the request cycle. Misses stall, write back a
// modified victim, refill word 0 upward and release the stall on the
// requested word. Assumes the processor holds its request until cpu_ready,
// power-of-two LINE_WORDS and NUM_LINES, and DATA_W a multiple of 8.
module line_cache_ctrl
    import cache_ctrl_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int NUM_LINES  = 16
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 cpu_req,
    input  logic                                 cpu_we,
    input  logic [ADDR_W-1:0]                    cpu_addr,
    input  logic [DATA_W-1:0]                    cpu_wdata,
    input  logic [DATA_W/8-1:0]                  cpu_be,
    output logic                                 cpu_ready,
    output logic [DATA_W-1:0]                    cpu_rdata,
    output logic                                 mem_req,
    output logic                                 mem_we,
    output logic [ADDR_W-$clog2(LINE_WORDS)-1:0] mem_line_addr,
    output logic [DATA_W-1:0]                    mem_wdata,
    input  logic                                 mem_ack,
    input  logic [DATA_W-1:0]                    mem_rdata
);
    localparam int OFF_W   = $clog2(LINE_WORDS);
    localparam int IDX_W   = $clog2(NUM_LINES);
    localparam int TAG_W   = ADDR_W - OFF_W - IDX_W;
    localparam int BE_W    = DATA_W / 8;
    localparam int DEPTH   = NUM_LINES * LINE_WORDS;

    // Address fields of the live request.
    logic [TAG_W-1:0] cpu_tag;
    logic [IDX_W-1:0] cpu_idx;
    logic [OFF_W-1:0] cpu_off;
    assign cpu_tag = cpu_addr[ADDR_W-1 -: TAG_W];
    assign cpu_idx = cpu_addr[OFF_W +: IDX_W];
    assign cpu_off = cpu_addr[OFF_W-1:0];

    // Sequencer outputs.
    miss_state_t      state;
    logic [OFF_W-1:0] beat;
    logic             last_beat;

    // Captured miss request.
    logic [TAG_W-1:0]  miss_tag_q;
    logic [IDX_W-1:0]  miss_idx_q;
    logic [OFF_W-1:0]  miss_off_q;
    logic              miss_we_q;
    logic [DATA_W-1:0] miss_wdata_q;
    logic [BE_W-1:0]   miss_be_q;
    logic [TAG_W-1:0]  victim_tag_q;

    // Tag store interface.
    logic             idle;
    logic [IDX_W-1:0] look_idx;
    logic             line_valid;
    logic             line_dirty;
    logic [TAG_W-1:0] line_tag;

    logic hit;
    logic hit_wr;
    logic miss_start;
    logic refill_beat;
    logic crit_beat;
    logic fill_done;
    logic merge_now;

    logic [DATA_W-1:0] fill_word;
    logic [DATA_W-1:0] hit_word;
    logic              wr_en;
    logic [IDX_W+OFF_W-1:0] wr_addr;
    logic [BE_W-1:0]   wr_be;
    logic [DATA_W-1:0] wr_data;

    // Lookup and handshake decode.
    always_comb begin
        idle        = (state == ST_IDLE);
        look_idx    = idle ? cpu_idx : miss_idx_q;
        hit         = idle && cpu_req && line_valid && (line_tag == cpu_tag);
        hit_wr      = hit && cpu_we;
        miss_start  = idle && cpu_req && !hit;
        refill_beat = (state == ST_REFILL) && mem_ack;
        crit_beat   = refill_beat && (beat == miss_off_q) && cpu_req;
        fill_done   = refill_beat && last_beat;
        merge_now   = miss_we_q && (beat == miss_off_q);
    end

    // Processor response: hit data or the critical refill word.
    always_comb begin
        cpu_ready = hit || crit_beat;
        cpu_rdata = crit_beat ? mem_rdata : hit_word;
    end

    // Backing port drive.
    always_comb begin
        mem_req       = !idle;
        mem_we        = (state == ST_WRBACK);
        mem_line_addr = mem_we ? {victim_tag_q, miss_idx_q} : {miss_tag_q, miss_idx_q};
    end

    // Store-miss merge of enabled bytes into the arriving word.
    for (genvar b = 0; b < BE_W; b++) begin : g_merge
        assign fill_word[b*8 +: 8] = (merge_now && miss_be_q[b]) ?
                                     miss_wdata_q[b*8 +: 8] : mem_rdata[b*8 +: 8];
    end

    // Data store write selection: refill beat or store hit.
    always_comb begin
        wr_en   = hit_wr || refill_beat;
        wr_addr = refill_beat ? {miss_idx_q, beat} : {cpu_idx, cpu_off};
        wr_be   = refill_beat ? {BE_W{1'b1}} : cpu_be;
        wr_data = refill_beat ? fill_word : cpu_wdata;
    end

    // Capture the missing request and the victim's tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            miss_tag_q   <= '0;
            miss_idx_q   <= '0;
            miss_off_q   <= '0;
            miss_we_q    <= 1'b0;
            miss_wdata_q <= '0;
            miss_be_q    <= '0;
            victim_tag_q <= '0;
        end else if (miss_start) begin
            miss_tag_q   <= cpu_tag;
            miss_idx_q   <= cpu_idx;
            miss_off_q   <= cpu_off;
            miss_we_q    <= cpu_we;
            miss_wdata_q <= cpu_wdata;
            miss_be_q    <= cpu_be;
            victim_tag_q <= line_tag;
        end
    end

    cache_miss_fsm #(
        .LINE_WORDS(LINE_WORDS)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .miss_start  (miss_start),
        .victim_dirty(line_valid && line_dirty),
        .mem_ack     (mem_ack),
        .state_o     (state),
        .beat_o      (beat),
        .last_beat_o (last_beat)
    );

    cache_tag_store #(
        .NUM_LINES(NUM_LINES),
        .TAG_W    (TAG_W)
    ) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (look_idx),
        .rd_valid  (line_valid),
        .rd_dirty  (line_dirty),
        .rd_tag    (line_tag),
        .mark_dirty(hit_wr),
        .mark_idx  (cpu_idx),
        .fill_en   (fill_done),
        .fill_idx  (miss_idx_q),
        .fill_tag  (miss_tag_q),
        .fill_dirty(miss_we_q)
    );

    cache_data_store #(
        .DEPTH (DEPTH),
        .DATA_W(DATA_W)
    ) u_data (
        .clk    (clk),
        .ra_addr({cpu_idx, cpu_off}),
        .ra_data(hit_word),
        .rb_addr({miss_idx_q, beat}),
        .rb_data(mem_wdata),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_be  (wr_be),
        .wr_data(wr_data)
    );

    AST_READY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> cpu_req); // R3
    AST_NO_READY_IN_WB: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !cpu_ready); // R7
    AST_WE_ONLY_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req); // R7
endmodule

// File: tb/sim_line_cache_ctrl.sv
`timescale 1ns/1ps
// Self-checking bench: small configuration, reference memory and tag model
// kept in the bench, randomised mem_ack gaps.
module sim_line_cache_ctrl;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam int LW = 4;
    localparam int NL = 4;
    localparam int TW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0;
    logic          cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic [3:0]    cpu_be = '0;
    logic          cpu_ready;
    logic [DW-1:0] cpu_rdata;
    logic          mem_req;
    logic          mem_we;
    logic [5:0]    mem_line_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_ack = 1'b0;
    logic [DW-1:0] mem_rdata = '0;

    always #4 clk = ~clk;

    line_cache_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .LINE_WORDS(LW), .NUM_LINES(NL)
    ) u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_line_addr(mem_line_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    logic [DW-1:0] ref_mem [256];
    logic [DW-1:0] bk_mem  [256];
    logic          mvalid  [NL];
    logic          mdirty  [NL];
    logic [TW-1:0] mtag    [NL];
    int            checks = 0;
    int            errors = 0;
    int            cycles = 0;
    int            bcnt = 0;
    logic          prev_ack = 1'b0;
    logic [15:0]   gap = 16'hACE1;
    logic          exp_wb = 1'b0;
    logic [5:0]    exp_wb_line = '0;
    logic [31:0]   rng = 32'h1234_5678;

    task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Backing memory responder: drives ack and read data at the falling edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            bcnt = 0;
            prev_ack = 1'b0;
            mem_ack = 1'b0;
        end else begin
            if (prev_ack) bcnt = (bcnt + 1) % LW;
            gap = {gap[14:0], gap[15] ^ gap[13] ^ gap[12] ^ gap[10]};
            mem_ack = mem_req && (gap[1:0] != 2'b00);
            mem_rdata = bk_mem[{mem_line_addr, 2'(bcnt)}];
            if (mem_ack && mem_we) begin
                chk(exp_wb, "R6 write-back of clean or invalid victim", 32'(mem_we), 32'd0);
                chk(mem_line_addr == exp_wb_line, "R7 write-back line address",
                    32'(mem_line_addr), 32'(exp_wb_line));
                chk(mem_wdata == ref_mem[{mem_line_addr, 2'(bcnt)}], "R7 R11 write-back word",
                    mem_wdata, ref_mem[{mem_line_addr, 2'(bcnt)}]);
                bk_mem[{mem_line_addr, 2'(bcnt)}] = mem_wdata;
            end
            prev_ack = mem_ack;
        end
    end

    // Watchdog: a hung run is a failed check and still reports the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // One processor access with timing and data checks against the bench model.
    task automatic access(input bit we, input logic [7:0] a, input logic [31:0] d,
                          input logic [3:0] be, output logic [31:0] rd,
                          output bit was_hit, output bit stalled);
        logic [1:0] idx;
        logic [3:0] tg;
        logic [1:0] off;
        bit         done;
        int         n;
        idx = a[3:2];
        tg  = a[7:4];
        off = a[1:0];
        was_hit = mvalid[idx] && (mtag[idx] == tg);
        if (!was_hit) begin
            exp_wb = mvalid[idx] && mdirty[idx];
            exp_wb_line = {mtag[idx], idx};
        end
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_be = be;
        stalled = 1'b0; done = 1'b0; n = 0; rd = '0;
        while (!done) begin
            #2;
            if (cpu_ready) begin
                if (was_hit) begin
                    chk(!mem_req, "R10 hit served while refill busy", 32'(mem_req), 32'd0);
                end else begin
                    chk(mem_ack && !mem_we && (bcnt == int'(off)) && (mem_line_addr == {tg, idx}),
                        "R8 R2 ready not on critical refill beat", 32'(bcnt), 32'(off));
                end
                if (!we) begin
                    chk(cpu_rdata == ref_mem[a], was_hit ? "R3 hit load data" : "R5 R8 miss load data",
                        cpu_rdata, ref_mem[a]);
                end else begin
                    for (int b = 0; b < 4; b++) begin
                        if (be[b]) ref_mem[a][b*8 +: 8] = d[b*8 +: 8];
                    end
                end
                if (!was_hit) begin
                    mvalid[idx] = 1'b1;
                    mtag[idx]   = tg;
                    mdirty[idx] = we;
                end else if (we) begin
                    mdirty[idx] = 1'b1;
                end
                rd = cpu_rdata;
                done = 1'b1;
            end else begin
                stalled = 1'b1;
                if (was_hit && !mem_req) begin
                    chk(1'b0, "R3 R4 hit stalled with idle backing port", 32'd0, 32'd1);
                end
                n++;
                if (n > 400) begin
                    chk(1'b0, "R8 request never completed", 32'(n), 32'd0);
                    done = 1'b1;
                end
                @(negedge clk);
            end
        end
    endtask

    function automatic logic [31:0] next_rng(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    initial begin
        logic [31:0] rd;
        bit h;
        bit st;
        for (int i = 0; i < 256; i++) begin
            ref_mem[i] = {8'hA5, 8'(i), 8'(~i), 8'(i * 3)};
            bk_mem[i]  = ref_mem[i];
        end
        for (int i = 0; i < NL; i++) begin
            mvalid[i] = 1'b0; mdirty[i] = 1'b0; mtag[i] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk(!cpu_ready, "R1 ready low after reset", 32'(cpu_ready), 32'd0);
        chk(!mem_req, "R1 backing port idle after reset", 32'(mem_req), 32'd0);

        // First access must miss.
        access(1'b0, 8'h00, '0, '0, rd, h, st);
        chk(st, "R1 first access after reset stalls", 32'(st), 32'd1);

        // Ascending load sweep over the whole space.
        for (int a = 0; a < 256; a++) begin
            access(1'b0, 8'(a), '0, '0, rd, h, st);
        end

        // Descending stores with read-back; critical offsets 3,2,1,0 all used.
        for (int a = 255; a >= 0; a -= 3) begin
            access(1'b1, 8'(a), 32'hC0DE_0000 ^ 32'(a * 7919), 4'(a) | 4'b0001, rd, h, st);
            access(1'b0, 8'(a), '0, '0, rd, st, st);
            chk(rd == ref_mem[a], h ? "R4 store hit merge" : "R9 store miss allocate merge",
                rd, ref_mem[a]);
        end

        // Conflict on one slot index.
        access(1'b0, 8'h10, '0, '0, rd, h, st);
        access(1'b0, 8'h50, '0, '0, rd, h, st);
        chk(st, "R2 other tag at same index misses", 32'(st), 32'd1);
        access(1'b0, 8'h11, '0, '0, rd, h, st);
        chk(st, "R2 evicted line misses again", 32'(st), 32'd1);
        chk(rd == ref_mem[8'h11], "R2 reloaded data", rd, ref_mem[8'h11]);

        // Random mixed traffic.
        for (int i = 0; i < 2500; i++) begin
            rng = next_rng(rng);
            access(rng[8], rng[7:0], next_rng(rng), rng[12:9], rd, h, st);
        end

        // Final load sweep checks every word.
        for (int a = 0; a < 256; a++) begin
            access(1'b0, 8'(a), '0, '0, rd, h, st);
        end

        @(negedge clk);
        cpu_req = 1'b0;
        repeat (20) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule